// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is the operand stack of a zero-address datapath. The four entries nearest the top sit in registers. Anything deeper sits in a region of an external synchronous memory that starts at a fixed base address. Commands arrive over a valid/ready handshake. The commands push a word, pop, combine the two top entries (add, subtract, multiply), or replace the top with the memory word whose address it holds. The top entry is shown on a dedicated output, together with a flag that says whether the registers hold anything.

Memory is touched only when it has to be. A push that finds all registers occupied writes the deepest register to memory before it shifts. An operation that lacks operands in the registers, while memory still holds older entries, first pulls them back one at a time. During that time the block stalls its ready line. An operation that cannot be satisfied at all sets a sticky error flag and changes nothing.

Top module: `evs_top`

## Requirements
- R1: After reset the stack is empty: `tos_valid`=0, `tos`=0, `underflow_err`=0, `cmd_ready`=1, and the memory port is idle.
- R2: Command codes on `cmd_op` are 0 no-op, 1 push, 2 pop, 3 add, 4 subtract, 5 multiply, 6 indirect load. A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. A push puts `cmd_data` on top. A pop removes the top and exposes the previous entry, in last-in first-out order.
- R3: Add replaces the two top entries with their 16-bit wrapped sum, so the depth drops by one.
- R4: Subtract replaces the two top entries with (entry below top) minus (top), modulo 2^16.
- R5: Multiply replaces the two top entries with the low 16 bits of their product.
- R6: Indirect load replaces the top with the memory word at address `tos[7:0]`. Memory read data returns one cycle after the request, and `cmd_ready` is low until the new top is in place.
- R7: A push while four entries are in registers first writes the deepest register entry to address 0x80+m, where m is the number of entries already in memory, and then increments m. No other situation issues a memory write.
- R8: When an operation needs more operands than the registers hold and memory holds entries, `cmd_ready` drops. The block reads address 0x80+m-1, decrements m, and appends the word below the register entries. It repeats this until enough operands are present, then executes.
- R9: A pop, load or binary operation that needs more operands than registers and memory hold together sets `underflow_err`, which stays set until reset. The stack contents are left unchanged.
- R10: Evaluating a b c * + a d c * + e - never exceeds four entries and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 16 | Word for push |
| cmd_ready | output | 1 | Block can take a command |
| tos | output | 16 | Top register entry, 0 when registers are empty |
| tos_valid | output | 1 | Registers hold at least one entry |
| underflow_err | output | 1 | Sticky underflow flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request. They also assume the spill region never grows large enough to wrap the 8-bit address. The bench's memory model is a registered array with that latency. No test pushes more than a handful of entries past the register capacity. The bench presents commands only at falling edges and holds them until ready is seen, so that no command is offered while a fill or a load is still in flight.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MUL  = 3'd5,
        OP_LOAD = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        RF_HOLD,
        RF_PUSH,
        RF_POP,
        RF_BIN,
        RF_FILL,
        RF_REPL
    } rf_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL_RD,
        S_FILL_CAP,
        S_EXEC,
        S_LD_CAP
    } st_e;

    // operand count each command consumes
    function automatic logic [1:0] need_of(op_e op);
        case (op)
            OP_POP, OP_LOAD:        need_of = 2'd1;
            OP_ADD, OP_SUB, OP_MUL: need_of = 2'd2;
            default:                need_of = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/evs_alu.sv
module evs_alu
    import evs_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    logic [2*DW-1:0] prod;

    assign prod = a * b;

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DW-1:0];
            default: y = b;
        endcase
    end
endmodule

// File: rtl/evs_regfile.sv
module evs_regfile
    import evs_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int CW = $clog2(N+1)
) (
    input  logic          clk,
    input  logic          rst,
    input  rf_e           cmd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] top,
    output logic [DW-1:0] second,
    output logic [DW-1:0] bottom,
    output logic [CW-1:0] count
);
    logic [DW-1:0] ent [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam int UP = (i > 0) ? i - 1 : 0;
        localparam int DN = (i < N - 1) ? i + 1 : i;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else begin
                case (cmd)
                    RF_PUSH: ent[i] <= (i == 0) ? din : ent[UP];
                    RF_POP:  ent[i] <= (i == N - 1) ? '0 : ent[DN];
                    RF_BIN:  ent[i] <= (i == 0) ? din : ((i == N - 1) ? '0 : ent[DN]);
                    RF_FILL: if (count == CW'(i)) ent[i] <= din;
                    RF_REPL: if (i == 0) ent[i] <= din;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (cmd)
                RF_PUSH: if (count != CW'(N)) count <= count + 1'b1;
                RF_POP, RF_BIN: count <= count - 1'b1;
                RF_FILL: count <= count + 1'b1;
                default: ;
            endcase
        end
    end

    assign top    = ent[0];
    assign second = ent[1];
    assign bottom = ent[N-1];

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(N));

    // R8
    fill_room_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == RF_FILL) |-> (count < CW'(N)));

    // R2
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == RF_POP || cmd == RF_BIN) |-> (count != '0));

endmodule

// File: rtl/evs_top.sv
module evs_top
    import evs_pkg::*;
#(
    parameter int          N          = 4,
    parameter int          DW         = 16,
    parameter int          AW         = 8,
    parameter logic [7:0]  SPILL_BASE = 8'h80
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          cmd_ready,
    output logic [DW-1:0] tos,
    output logic          tos_valid,
    output logic          underflow_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int CW = $clog2(N+1);
    localparam logic [AW-1:0] BASE = AW'(SPILL_BASE);

    st_e           st, st_n;
    op_e           cur_op, op_n, act_op;
    logic [AW-1:0] mcnt, mcnt_n;
    logic          err_n;
    logic          accept, short, exec_go;
    logic [1:0]    need;
    logic [AW:0]   total;
    rf_e           rf_cmd;
    logic [DW-1:0] rf_din, rf_top, rf_second, rf_bottom, alu_y;
    logic [CW-1:0] rcount;

    evs_regfile #(.N(N), .DW(DW), .CW(CW)) u_rf (
        .clk(clk), .rst(rst), .cmd(rf_cmd), .din(rf_din),
        .top(rf_top), .second(rf_second), .bottom(rf_bottom), .count(rcount)
    );

    evs_alu #(.DW(DW)) u_alu (
        .op(act_op), .a(rf_second), .b(rf_top), .y(alu_y)
    );

    assign cmd_ready = (st == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign act_op    = (st == S_IDLE) ? op_e'(cmd_op) : cur_op;
    assign need      = need_of(act_op);
    assign total     = {1'b0, mcnt} + (AW+1)'(rcount);
    assign short     = total < (AW+1)'(need);
    assign tos       = (rcount != '0) ? rf_top : '0;
    assign tos_valid = (rcount != '0);

    always_comb begin
        st_n      = st;
        op_n      = cur_op;
        mcnt_n    = mcnt;
        err_n     = underflow_err;
        rf_cmd    = RF_HOLD;
        rf_din    = alu_y;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = rf_bottom;
        exec_go   = 1'b0;
        case (st)
            S_IDLE: begin
                if (accept) begin
                    if (short) begin
                        err_n = 1'b1;
                    end else if (act_op == OP_PUSH) begin
                        rf_cmd = RF_PUSH;
                        rf_din = cmd_data;
                        if (rcount == CW'(N)) begin
                            mem_req  = 1'b1;
                            mem_we   = 1'b1;
                            mem_addr = BASE + mcnt;
                            mcnt_n   = mcnt + 1'b1;
                        end
                    end else if (rcount < CW'(need)) begin
                        op_n = act_op;
                        st_n = S_FILL_RD;
                    end else begin
                        exec_go = 1'b1;
                    end
                end
            end
            S_FILL_RD: begin
                mem_req  = 1'b1;
                mem_addr = BASE + mcnt - 1'b1;
                mcnt_n   = mcnt - 1'b1;
                st_n     = S_FILL_CAP;
            end
            S_FILL_CAP: begin
                rf_cmd = RF_FILL;
                rf_din = mem_rdata;
                st_n   = ((rcount + 1'b1) < CW'(need)) ? S_FILL_RD : S_EXEC;
            end
            S_EXEC: begin
                exec_go = 1'b1;
                st_n    = S_IDLE;
            end
            S_LD_CAP: begin
                rf_cmd = RF_REPL;
                rf_din = mem_rdata;
                st_n   = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
        if (exec_go) begin
            case (act_op)
                OP_POP: rf_cmd = RF_POP;
                OP_ADD, OP_SUB, OP_MUL: rf_cmd = RF_BIN;
                OP_LOAD: begin
                    mem_req  = 1'b1;
                    mem_addr = rf_top[AW-1:0];
                    st_n     = S_LD_CAP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= S_IDLE;
            cur_op        <= OP_NOP;
            mcnt          <= '0;
            underflow_err <= 1'b0;
        end else begin
            st            <= st_n;
            cur_op        <= op_n;
            mcnt          <= mcnt_n;
            underflow_err <= err_n;
        end
    end

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && act_op == OP_PUSH) |=> (tos == $past(cmd_data)));

    // R3
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && act_op == OP_ADD && rcount >= CW'(2))
        |=> (tos == $past(DW'(rf_second + rf_top))));

    // R7
    spill_write_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && act_op == OP_PUSH && rcount == CW'(N))
        |-> (mem_req && mem_we && mem_wdata == rf_bottom && mem_addr == BASE + mcnt));

    // R7
    write_only_spill_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (accept && act_op == OP_PUSH && rcount == CW'(N)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_err |=> underflow_err);

    // R9
    underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && short && act_op != OP_PUSH)
        |=> (rcount == $past(rcount) && rf_top == $past(rf_top) && mcnt == $past(mcnt)));

    // R8
    fill_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_FILL_RD) |-> (!cmd_ready && mem_req && !mem_we && mcnt != '0));

endmodule

// File: tb/sim_evs_top.sv
module sim_evs_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_data;
    logic        cmd_ready;
    logic [15:0] tos;
    logic        tos_valid;
    logic        underflow_err;
    logic        mem_req;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    logic [15:0] mem [0:255];
    int          wr_count = 0;
    int          req_count = 0;
    int          checks = 0;
    int          fails = 0;
    int          stalls;

    localparam logic [2:0] C_NOP = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2, C_ADD = 3'd3,
                           C_SUB = 3'd4, C_MUL = 3'd5, C_LOAD = 3'd6;

    always #5 clk = ~clk;

    evs_top u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .tos(tos), .tos_valid(tos_valid),
        .underflow_err(underflow_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            req_count <= req_count + 1;
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_count      <= wr_count + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one command, then wait until the block is idle again
    task automatic do_cmd(input logic [2:0] op, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = C_NOP;
        stalls    = 0;
        while (!cmd_ready) begin
            @(negedge clk);
            stalls++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 tos_valid", {15'd0, tos_valid}, 16'd0);
        chk("R1 tos", tos, 16'd0);
        chk("R1 err", {15'd0, underflow_err}, 16'd0);
        chk("R1 ready", {15'd0, cmd_ready}, 16'd1);
        chk("R1 mem_req", {15'd0, mem_req}, 16'd0);
    endtask

    task automatic t_lifo;
        do_cmd(C_PUSH, 16'h0001); chk("R2 push1", tos, 16'h0001);
        do_cmd(C_PUSH, 16'h0002); chk("R2 push2", tos, 16'h0002);
        do_cmd(C_PUSH, 16'h0003); chk("R2 push3", tos, 16'h0003);
        do_cmd(C_NOP, 16'h0000);  chk("R2 nop", tos, 16'h0003);
        do_cmd(C_POP, 16'h0000);  chk("R2 pop1", tos, 16'h0002);
        do_cmd(C_POP, 16'h0000);  chk("R2 pop2", tos, 16'h0001);
        do_cmd(C_POP, 16'h0000);  chk("R2 empty", {15'd0, tos_valid}, 16'd0);
    endtask

    task automatic t_arith;
        do_cmd(C_PUSH, 16'hFFFF); do_cmd(C_PUSH, 16'h0002); do_cmd(C_ADD, 16'h0);
        chk("R3 add wrap", tos, 16'h0001);
        do_cmd(C_POP, 16'h0);
        chk("R3 depth-1", {15'd0, tos_valid}, 16'd0);
        do_cmd(C_PUSH, 16'd5); do_cmd(C_PUSH, 16'd9); do_cmd(C_SUB, 16'h0);
        chk("R4 sub order", tos, 16'hFFFC);
        do_cmd(C_PUSH, 16'd3); do_cmd(C_SUB, 16'h0);
        chk("R4 sub2", tos, 16'hFFF9);
        do_cmd(C_POP, 16'h0);
        do_cmd(C_PUSH, 16'h1234); do_cmd(C_PUSH, 16'h0100); do_cmd(C_MUL, 16'h0);
        chk("R5 mul low", tos, 16'h3400);
        do_cmd(C_POP, 16'h0);
    endtask

    task automatic t_expr;
        int w0, r0;
        w0 = wr_count; r0 = req_count;
        do_cmd(C_PUSH, 16'd3); do_cmd(C_PUSH, 16'd5); do_cmd(C_PUSH, 16'd7);
        do_cmd(C_MUL, 0); do_cmd(C_ADD, 0);
        do_cmd(C_PUSH, 16'd3); do_cmd(C_PUSH, 16'd2); do_cmd(C_PUSH, 16'd7);
        do_cmd(C_MUL, 0); do_cmd(C_ADD, 0);
        do_cmd(C_PUSH, 16'd4); do_cmd(C_SUB, 0);
        chk("R10 right term", tos, 16'd13);
        do_cmd(C_POP, 0);
        chk("R10 left term", tos, 16'd38);
        do_cmd(C_POP, 0);
        chk("R10 no mem traffic", 16'(req_count - r0), 16'd0);
        chk("R10 no mem writes", 16'(wr_count - w0), 16'd0);
    endtask

    task automatic t_load;
        mem[8'h05] = 16'h1234;
        do_cmd(C_PUSH, 16'h0005);
        do_cmd(C_LOAD, 0);
        chk("R6 load value", tos, 16'h1234);
        chk("R6 load stall", 16'(stalls > 0), 16'd1);
        do_cmd(C_POP, 0);
    endtask

    task automatic t_spill_fill;
        int w0;
        w0 = wr_count;
        mem[8'h11] = 16'hBEEF;
        for (int i = 1; i <= 6; i++) do_cmd(C_PUSH, 16'(16'h10 + i));
        chk("R7 spill count", 16'(wr_count - w0), 16'd2);
        chk("R7 spill first", mem[8'h80], 16'h0011);
        chk("R7 spill second", mem[8'h81], 16'h0012);
        chk("R7 top after spill", tos, 16'h0016);
        do_cmd(C_POP, 0); do_cmd(C_POP, 0); do_cmd(C_POP, 0);
        chk("R8 pops", tos, 16'h0013);
        do_cmd(C_ADD, 0);
        chk("R8 fill then add", tos, 16'h0025);
        chk("R8 fill stall", 16'(stalls > 0), 16'd1);
        do_cmd(C_POP, 0);
        chk("R8 regs empty", {15'd0, tos_valid}, 16'd0);
        do_cmd(C_LOAD, 0);
        chk("R8 fill then load", tos, 16'hBEEF);
        do_cmd(C_POP, 0);
        chk("R7 no extra writes", 16'(wr_count - w0), 16'd2);
    endtask

    task automatic t_underflow;
        chk("R9 err clear before", {15'd0, underflow_err}, 16'd0);
        do_cmd(C_POP, 0);
        chk("R9 err on empty pop", {15'd0, underflow_err}, 16'd1);
        chk("R9 still empty", {15'd0, tos_valid}, 16'd0);
        do_cmd(C_PUSH, 16'h0077);
        do_cmd(C_ADD, 0);
        chk("R9 top unchanged", tos, 16'h0077);
        chk("R9 entry kept", {15'd0, tos_valid}, 16'd1);
        do_cmd(C_PUSH, 16'h0088);
        do_cmd(C_ADD, 0);
        chk("R9 works after", tos, 16'h00FF);
        chk("R9 err sticky", {15'd0, underflow_err}, 16'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        mem_rdata = 16'h0;
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_op    = C_NOP;
        cmd_data  = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lifo();
        t_arith();
        t_expr();
        t_load();
        t_spill_fill();
        t_underflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule